// File: doc/BRIEF.md
# Page Transfer and Compare Engine

This block is the internal sequencer that moves data between a paged main memory array and a pair of page buffers. A single start request carries an operation code, a buffer select and a page number. The engine then walks every byte of the page, one byte per clock, over synchronous memory ports. The main memory and the two buffers sit outside the block, and each has a read latency of one cycle.

Three operations exist. A copy loads the chosen buffer from the page. A check reads the page and the buffer side by side and records in a status flag whether any byte differed. A refresh first copies the page into the buffer and then writes that buffer back into the same page. It then stays busy for a programmable count of cycles, which stands in for the self-timed program delay. A busy flag covers each operation from start to finish, and a one-cycle done pulse marks the end.

Top module: `page_op_engine`

## Requirements
- R1: After reset, busy, done and cmpMismatch are 0, and no memory read or write enable is asserted.
- R2: A start is taken only when startValid is high while busy is low and startOp is not 2'b11. Busy then rises in the next cycle. A start with startOp 2'b11, or any start while busy is high, is ignored and leaves the memories and the running operation untouched.
- R3: Copy (startOp 2'b00) writes all PAGE_BYTES bytes of page startPage into the buffer chosen by startBuf (0 selects the first buffer, 1 the second). The other buffer and the main memory stay unchanged.
- R4: Check (startOp 2'b01) sets cmpMismatch to 0 when every byte of the page equals the same byte of the chosen buffer, and to 1 when any byte differs, including byte 0 and the last byte. cmpMismatch keeps its value through copies and refreshes until the next check.
- R5: Refresh (startOp 2'b10) leaves the chosen buffer equal to the page. It then issues exactly PAGE_BYTES main-memory writes of that buffer data to the same page, so that no other page changes.
- R6: Busy stays high for PAGE_BYTES+1 cycles during a copy or a check. During a refresh it stays high for 2*(PAGE_BYTES+1)+WAIT_CYCLES cycles.
- R7: done is high for exactly one cycle, and that cycle is the first cycle in which busy is low again.
- R8: Main memory is written only during a refresh. A main-memory write and a buffer write never occur in the same cycle, and no enable is asserted while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request strobe |
| startOp | input | 2 | 00 copy, 01 check, 10 refresh, 11 reserved |
| startBuf | input | 1 | Buffer select for the request |
| startPage | input | PAGE_BITS | Page number for the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cmpMismatch | output | 1 | Result of the last check, 1 means a difference was found |
| memPage | output | PAGE_BITS | Main-memory page address |
| memByte | output | BYTE_AW | Main-memory byte address within the page |
| memRdEn | output | 1 | Main-memory read enable |
| memRdData | input | 8 | Main-memory read data, one cycle after memRdEn |
| memWrEn | output | 1 | Main-memory write enable |
| memWrData | output | 8 | Main-memory write data |
| bufSel | output | 1 | Buffer select |
| bufByte | output | BYTE_AW | Buffer byte address |
| bufRdEn | output | 1 | Buffer read enable |
| bufRdData | input | 8 | Buffer read data, one cycle after bufRdEn |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrData | output | 8 | Buffer write data |

## Verification
The hardest cases to reach are checks whose only difference sits at byte 0 or at the last byte. In the last-byte case the differing compare lands in the same cycle that the result is latched. The bench corrupts a single byte of its buffer model at exactly those positions, and it also flips random bytes before randomly chosen checks. A second hard case is a start request that arrives halfway through a copy. The bench pulses such a request into the second buffer during a run, then confirms at the ports that the busy length is unchanged and that the buffer contents are untouched.

// File: rtl/page_op_pkg.sv
package page_op_pkg;

  typedef enum logic [1:0] {
    OP_COPY  = 2'b00,
    OP_CHECK = 2'b01,
    OP_REFR  = 2'b10,
    OP_NONE  = 2'b11
  } opKind_t;

  typedef enum logic [1:0] {
    PH_MEM2BUF = 2'b00,
    PH_CHECK   = 2'b01,
    PH_BUF2MEM = 2'b10
  } phase_t;

  typedef struct packed {
    logic   clear;
    logic   issue;
    phase_t phase;
    logic   cmpClear;
    logic   latchResult;
  } ctrlStrobe_t;

endpackage

// File: rtl/page_op_dp.sv
module page_op_dp
  import page_op_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int DATA_W     = 8,
  parameter int BYTE_AW    = $clog2(PAGE_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  output logic                loopEnd,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic [BYTE_AW-1:0]  memByte,
  output logic [DATA_W-1:0]   memWrData,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                bufRdEn,
  output logic                bufWrEn,
  output logic [BYTE_AW-1:0]  bufByte,
  output logic [DATA_W-1:0]   bufWrData,
  input  logic [DATA_W-1:0]   bufRdData,
  output logic                cmpMismatch
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0]   issueCnt;
  logic [BYTE_AW-1:0] issueAddr;
  logic               issuing;
  logic               pipeValid;
  logic [BYTE_AW-1:0] pipeByte;
  logic               diffAcc;
  logic               byteDiff;

  assign issueAddr = issueCnt[BYTE_AW-1:0];
  assign issuing   = strobe.issue && (issueCnt < CNT_END);
  assign loopEnd   = (issueCnt == CNT_END);
  assign byteDiff  = pipeValid && (strobe.phase == PH_CHECK) && (memRdData != bufRdData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueCnt    <= '0;
      pipeValid   <= 1'b0;
      pipeByte    <= '0;
      diffAcc     <= 1'b0;
      cmpMismatch <= 1'b0;
    end else begin
      if (strobe.clear)   issueCnt <= '0;
      else if (issuing)   issueCnt <= issueCnt + 1'b1;
      pipeValid <= issuing;
      pipeByte  <= issueAddr;
      if (strobe.cmpClear)  diffAcc <= 1'b0;
      else if (byteDiff)    diffAcc <= 1'b1;
      if (strobe.latchResult) cmpMismatch <= diffAcc | byteDiff;
    end
  end

  assign memRdEn   = issuing && (strobe.phase != PH_BUF2MEM);
  assign bufRdEn   = issuing && (strobe.phase != PH_MEM2BUF);
  assign memWrEn   = pipeValid && (strobe.phase == PH_BUF2MEM);
  assign bufWrEn   = pipeValid && (strobe.phase == PH_MEM2BUF);
  assign memByte   = (strobe.phase == PH_BUF2MEM) ? pipeByte : issueAddr;
  assign bufByte   = (strobe.phase == PH_MEM2BUF) ? pipeByte : issueAddr;
  assign memWrData = bufRdData;
  assign bufWrData = memRdData;

endmodule

// File: rtl/page_op_ctrl.sv
module page_op_ctrl
  import page_op_pkg::*;
#(
  parameter int PAGE_BITS   = 12,
  parameter int WAIT_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic [1:0]           startOp,
  input  logic                 startBuf,
  input  logic [PAGE_BITS-1:0] startPage,
  input  logic                 loopEnd,
  output ctrlStrobe_t          strobe,
  output logic                 busy,
  output logic                 done,
  output logic                 bufSel,
  output logic [PAGE_BITS-1:0] memPage
);

  localparam int WAIT_W    = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam int WAIT_LAST = (WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0;

  typedef enum logic [2:0] {
    S_IDLE, S_COPY, S_CHECK, S_WRBACK, S_WAIT
  } state_t;

  state_t            state, nextState;
  opKind_t           opReg;
  opKind_t           reqOp;
  logic              accept;
  logic [WAIT_W-1:0] waitCnt;

  assign reqOp  = opKind_t'(startOp);
  assign accept = (state == S_IDLE) && startValid && (reqOp != OP_NONE);
  assign busy   = (state != S_IDLE);

  always_comb begin
    nextState          = state;
    strobe.clear       = 1'b0;
    strobe.issue       = 1'b0;
    strobe.phase       = PH_MEM2BUF;
    strobe.cmpClear    = 1'b0;
    strobe.latchResult = 1'b0;
    case (state)
      S_IDLE: begin
        if (accept) begin
          strobe.clear    = 1'b1;
          strobe.cmpClear = (reqOp == OP_CHECK);
          nextState       = (reqOp == OP_CHECK) ? S_CHECK : S_COPY;
        end
      end
      S_COPY: begin
        strobe.issue = 1'b1;
        if (loopEnd) begin
          if (opReg == OP_REFR) begin
            strobe.clear = 1'b1;
            nextState    = S_WRBACK;
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      S_CHECK: begin
        strobe.issue = 1'b1;
        strobe.phase = PH_CHECK;
        if (loopEnd) begin
          strobe.latchResult = 1'b1;
          nextState          = S_IDLE;
        end
      end
      S_WRBACK: begin
        strobe.issue = 1'b1;
        strobe.phase = PH_BUF2MEM;
        if (loopEnd) nextState = (WAIT_CYCLES == 0) ? S_IDLE : S_WAIT;
      end
      S_WAIT: begin
        strobe.phase = PH_BUF2MEM;
        if (waitCnt == WAIT_W'(WAIT_LAST)) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_COPY;
      bufSel  <= 1'b0;
      memPage <= '0;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state != S_IDLE) && (nextState == S_IDLE);
      if (accept) begin
        opReg   <= reqOp;
        bufSel  <= startBuf;
        memPage <= startPage;
      end
      if (state != S_WAIT) waitCnt <= '0;
      else                 waitCnt <= waitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/page_op_engine.sv
module page_op_engine
  import page_op_pkg::*;
#(
  parameter int PAGE_BYTES  = 264,
  parameter int PAGE_BITS   = 12,
  parameter int WAIT_CYCLES = 8,
  parameter int DATA_W      = 8,
  localparam int BYTE_AW    = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic [1:0]           startOp,
  input  logic                 startBuf,
  input  logic [PAGE_BITS-1:0] startPage,
  output logic                 busy,
  output logic                 done,
  output logic                 cmpMismatch,
  output logic [PAGE_BITS-1:0] memPage,
  output logic [BYTE_AW-1:0]   memByte,
  output logic                 memRdEn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 memWrEn,
  output logic [DATA_W-1:0]    memWrData,
  output logic                 bufSel,
  output logic [BYTE_AW-1:0]   bufByte,
  output logic                 bufRdEn,
  input  logic [DATA_W-1:0]    bufRdData,
  output logic                 bufWrEn,
  output logic [DATA_W-1:0]    bufWrData
);

  ctrlStrobe_t strobe;
  logic        loopEnd;

  page_op_ctrl #(
    .PAGE_BITS  (PAGE_BITS),
    .WAIT_CYCLES(WAIT_CYCLES)
  ) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .startOp   (startOp),
    .startBuf  (startBuf),
    .startPage (startPage),
    .loopEnd   (loopEnd),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .bufSel    (bufSel),
    .memPage   (memPage)
  );

  page_op_dp #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W),
    .BYTE_AW   (BYTE_AW)
  ) dpI (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loopEnd    (loopEnd),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn),
    .memByte    (memByte),
    .memWrData  (memWrData),
    .memRdData  (memRdData),
    .bufRdEn    (bufRdEn),
    .bufWrEn    (bufWrEn),
    .bufByte    (bufByte),
    .bufWrData  (bufWrData),
    .bufRdData  (bufRdData),
    .cmpMismatch(cmpMismatch)
  );

endmodule

// File: rtl/page_op_chk.sv
module page_op_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startValid,
  input logic [1:0] startOp,
  input logic       busy,
  input logic       done,
  input logic       cmpMismatch,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic       bufRdEn,
  input logic       bufWrEn
);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy && (startOp != 2'b11)) |=> busy); // R2

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (!startValid || (startOp == 2'b11))) |=> !busy); // R2

  AST_FLAG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(cmpMismatch)); // R4

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && bufWrEn)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memRdEn || memWrEn || bufRdEn || bufWrEn)); // R8

endmodule

bind page_op_engine page_op_chk chkI (.*);

// File: tb/page_op_engine_test.sv
module page_op_engine_test;

  localparam int PB   = 264;
  localparam int PGB  = 4;
  localparam int NPG  = 1 << PGB;
  localparam int WT   = 5;
  localparam int BAW  = $clog2(PB);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startValid = 1'b0;
  logic [1:0]     startOp = 2'b00;
  logic           startBuf = 1'b0;
  logic [PGB-1:0] startPage = '0;
  logic           busy, done, cmpMismatch;
  logic [PGB-1:0] memPage;
  logic [BAW-1:0] memByte, bufByte;
  logic           memRdEn, memWrEn, bufSel, bufRdEn, bufWrEn;
  logic [7:0]     memRdData, memWrData, bufRdData, bufWrData;

  page_op_engine #(.PAGE_BYTES(PB), .PAGE_BITS(PGB), .WAIT_CYCLES(WT)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .startBuf(startBuf), .startPage(startPage), .busy(busy), .done(done),
    .cmpMismatch(cmpMismatch), .memPage(memPage), .memByte(memByte),
    .memRdEn(memRdEn), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrData(memWrData), .bufSel(bufSel), .bufByte(bufByte),
    .bufRdEn(bufRdEn), .bufRdData(bufRdData), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData)
  );

  always #4 clk = ~clk;

  logic [7:0] mainMem [NPG*PB];
  logic [7:0] bufMem  [2][PB];
  logic [7:0] goldMain[NPG*PB];
  logic [7:0] goldBuf [2][PB];
  int memWrCount = 0;
  int errors = 0;
  int checks = 0;
  logic expFlag = 1'b0;

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mainMem[int'(memPage)*PB + int'(memByte)];
    if (memWrEn) begin
      mainMem[int'(memPage)*PB + int'(memByte)] <= memWrData;
      memWrCount <= memWrCount + 1;
    end
    if (bufRdEn) bufRdData <= bufMem[bufSel][bufByte];
    if (bufWrEn) bufMem[bufSel][bufByte] <= bufWrData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mainDiffs();
    int n = 0;
    for (int i = 0; i < NPG*PB; i++) if (mainMem[i] != goldMain[i]) n++;
    return n;
  endfunction

  function automatic int bufDiffs(input int b);
    int n = 0;
    for (int i = 0; i < PB; i++) if (bufMem[b][i] != goldBuf[b][i]) n++;
    return n;
  endfunction

  function automatic bit pageDiffers(input int b, input int pg);
    for (int i = 0; i < PB; i++) if (goldBuf[b][i] != goldMain[pg*PB + i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic goldCopy(input int b, input int pg);
    for (int i = 0; i < PB; i++) goldBuf[b][i] = goldMain[pg*PB + i];
  endtask

  task automatic poke(input int b, input int idx, input logic [7:0] v);
    bufMem[b][idx]  = v;
    goldBuf[b][idx] = v;
  endtask

  task automatic runOp(input logic [1:0] op, input logic b, input int pg,
                       output int busyCyc, output logic doneFirst, output logic doneAfter);
    int guard = 0;
    @(negedge clk);
    startValid = 1'b1; startOp = op; startBuf = b; startPage = PGB'(pg);
    @(negedge clk);
    startValid = 1'b0;
    busyCyc = 0;
    while (busy && guard < 5000) begin
      busyCyc++; guard++;
      @(negedge clk);
    end
    doneFirst = done;
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic doOp(input logic [1:0] op, input int b, input int pg, input string tag);
    int bc, w0;
    logic d0, d1;
    int expBusy;
    w0 = memWrCount;
    if (op == 2'b01) expFlag = pageDiffers(b, pg);
    else goldCopy(b, pg);
    expBusy = (op == 2'b10) ? 2*(PB+1) + WT : PB + 1;
    runOp(op, 1'(b), pg, bc, d0, d1);
    check(bc == expBusy, {tag, " R6 busy length"}, bc, expBusy);
    check(d0 && !d1, {tag, " R7 done pulse"}, {d0, d1}, 2);
    check(bufDiffs(0) == 0 && bufDiffs(1) == 0, {tag, " R3 buffers"}, bufDiffs(0) + bufDiffs(1), 0);
    check(mainDiffs() == 0, {tag, " R5 main memory"}, mainDiffs(), 0);
    check(cmpMismatch == expFlag, {tag, " R4 compare flag"}, cmpMismatch, expFlag);
    if (op == 2'b10)
      check(memWrCount - w0 == PB, {tag, " R5 write count"}, memWrCount - w0, PB);
    else
      check(memWrCount == w0, {tag, " R8 no main write"}, memWrCount - w0, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < NPG*PB; i++) begin
      mainMem[i] = 8'($urandom);
      goldMain[i] = mainMem[i];
    end
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < PB; i++) begin
        bufMem[b][i] = 8'($urandom);
        goldBuf[b][i] = bufMem[b][i];
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !cmpMismatch, "R1 reset outputs", {busy, done, cmpMismatch}, 0);
    check(!(memRdEn || memWrEn || bufRdEn || bufWrEn), "R1 reset enables",
          {memRdEn, memWrEn, bufRdEn, bufWrEn}, 0);

    // R2 reserved opcode ignored
    @(negedge clk);
    startValid = 1'b1; startOp = 2'b11; startBuf = 1'b0; startPage = 4'd2;
    @(negedge clk);
    startValid = 1'b0;
    check(!busy, "R2 reserved op busy", busy, 0);
    repeat (3) @(negedge clk);
    check(bufDiffs(0) == 0 && mainDiffs() == 0, "R2 reserved op memories", bufDiffs(0), 0);

    // R3 copies into each buffer, last page included
    doOp(2'b00, 0, 3, "copy b0 p3");
    doOp(2'b00, 1, NPG - 1, "copy b1 plast");

    // R4 check: match, first byte, last byte
    doOp(2'b01, 1, NPG - 1, "check match");
    poke(1, 0, goldBuf[1][0] ^ 8'h01);
    doOp(2'b01, 1, NPG - 1, "check diff byte0");
    poke(1, 0, goldMain[(NPG-1)*PB]);
    poke(1, PB - 1, goldBuf[1][PB-1] ^ 8'h80);
    doOp(2'b01, 1, NPG - 1, "check diff last");
    // R4 flag held across a copy
    doOp(2'b00, 0, 5, "copy keeps flag");
    doOp(2'b01, 0, 5, "check match b0");

    // R5 refresh with junk buffer beforehand
    for (int i = 0; i < PB; i++) poke(0, i, 8'($urandom));
    doOp(2'b10, 0, 7, "refresh b0 p7");
    doOp(2'b10, 1, 0, "refresh b1 p0");

    // R2 start while busy is ignored
    begin
      int bc, guard;
      goldCopy(0, 2);
      @(negedge clk);
      startValid = 1'b1; startOp = 2'b00; startBuf = 1'b0; startPage = 4'd2;
      @(negedge clk);
      startValid = 1'b0;
      bc = 1;
      repeat (9) begin @(negedge clk); bc++; end
      startValid = 1'b1; startOp = 2'b00; startBuf = 1'b1; startPage = 4'd9;
      @(negedge clk);
      startValid = 1'b0; bc++;
      guard = 0;
      while (busy && guard < 5000) begin @(negedge clk); bc++; guard++; end
      bc--;
      check(bc == PB + 1, "R2 busy start ignored length", bc, PB + 1);
      check(bufDiffs(1) == 0 && bufDiffs(0) == 0, "R2 busy start ignored buffers",
            bufDiffs(1) + bufDiffs(0), 0);
    end

    // random mix
    for (int n = 0; n < 20; n++) begin
      int op, b, pg;
      op = int'($urandom_range(2, 0));
      b  = int'($urandom_range(1, 0));
      pg = int'($urandom_range(NPG - 1, 0));
      if (op == 1 && $urandom_range(1, 0) == 1) begin
        goldCopy(b, pg);
        for (int i = 0; i < PB; i++) bufMem[b][i] = goldBuf[b][i];
        if ($urandom_range(1, 0) == 1) begin
          int k;
          k = int'($urandom_range(PB - 1, 0));
          poke(b, k, goldBuf[b][k] ^ 8'h5A);
        end
      end
      doOp(2'(op), b, pg, $sformatf("random %0d", n));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule